// File: doc/BRIEF.md
# Overlapping register window file

This block is the integer register file of a processor that keeps procedure frames in registers instead of memory. Physical storage consists of a small globals area that every procedure sees, plus a ring of windows. Each window presents three groups of eight architectural registers: incoming parameters, locals and outgoing temporaries. The outgoing temporaries of a window are the same physical registers as the incoming parameters of the next window on the ring. A caller leaves its arguments in its temporaries, and after the call the callee finds them in its parameters with no copying.

A current window pointer advances on a call and steps back on a return, wrapping around the ring. A saved window pointer, together with a count of spilled windows, tells the block when the ring is full or when a return would reach a window whose contents are in memory. In those cases it raises an overflow or underflow trap for that cycle and leaves the current pointer where it is.

A trap handler uses a direct physical port to read or write any register by physical index. It reports that a window was saved or restored with a one-cycle pulse, which moves the saved window pointer. The trapped call or return can then be retried. Two combinational read ports and one clocked write port serve the datapath. All of them are addressed by 5-bit architectural register numbers, which are resolved against the current window.

Top module: `rwin_file`

## Requirements
- R1: After reset, cwp_o and swp_o are 0, the spilled count is 0, both traps are low, and every physical register reads 0.
- R2: Architectural registers 0 to 7 map to physical registers 0 to 7 in every window.
- R3: With current window w, registers 8 to 23 map to physical 8 + 16*w + (r-8). Registers 24 to 31 map to physical 8 + 16*((w+1) mod 8) + (r-24).
- R4: A value written to register 24+k in window w is read as register 8+k after a call into window w+1 (mod 8), for k = 0 to 7.
- R5: Both read ports are combinational and independent. A write through the architectural port becomes visible only after the next rising clock edge.
- R6: A call without trap sets cwp to (cwp+1) mod 8. A return without trap sets cwp to (cwp-1) mod 8. When call and return are asserted together, the call is taken and the return is ignored.
- R7: A call while (cwp+1) mod 8 equals swp drives ovf_trap_o high in that same cycle and leaves cwp unchanged.
- R8: A return, without a call, while cwp equals swp and the spilled count is nonzero drives unf_trap_o high in that same cycle and leaves cwp unchanged. A return never traps when the spilled count is 0.
- R9: A spill_done_i pulse sets swp to (swp+1) mod 8 and increments the spilled count. A fill_done_i pulse sets swp to (swp-1) mod 8 and decrements the count. A fill pulse is ignored when the count is 0, and both pulses together are ignored.
- R10: phys_rd_o returns the physical register at phys_addr_i combinationally. phys_we_i writes it at the clock edge and overrides an architectural write to the same physical index in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_i | input | 5 | Read port 1 register number |
| rs2_i | input | 5 | Read port 2 register number |
| rd1_o | output | 32 | Read port 1 data |
| rd2_o | output | 32 | Read port 2 data |
| we_i | input | 1 | Architectural write enable |
| wa_i | input | 5 | Architectural write register number |
| wd_i | input | 32 | Architectural write data |
| call_i | input | 1 | Call request |
| ret_i | input | 1 | Return request |
| ovf_trap_o | output | 1 | Window overflow trap |
| unf_trap_o | output | 1 | Window underflow trap |
| spill_done_i | input | 1 | Handler saved the oldest window |
| fill_done_i | input | 1 | Handler restored a window |
| phys_we_i | input | 1 | Physical port write enable |
| phys_addr_i | input | 8 | Physical register index |
| phys_wd_i | input | 32 | Physical port write data |
| phys_rd_o | output | 32 | Physical port read data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |

## Verification
A wrong current window pointer appears at once on both read ports. Each windowed register then returns the value of another physical slot, which the physical port has filled with a unique value. A corrupted saved pointer or spilled count cannot be seen directly. It appears only when a trap fires one call or return too early or too late, so the bench drives the ring to both the full and the drained edge and checks the trap in the cycle of the request. An error in the overlap decode shows up on the first read of a parameter after a call.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  parameter int unsigned ARCH_W = 5;
  typedef logic [ARCH_W-1:0] arch_reg_t;
endpackage

// File: rtl/rwin_map.sv
module rwin_map import rwin_pkg::*; #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned AREA  = 8,
  parameter int unsigned NGLOB = 8,
  parameter int unsigned AW    = 8,
  localparam int unsigned WB   = $clog2(NWIN),
  localparam int unsigned OB   = $clog2(2*AREA),
  localparam int unsigned TBASE = NGLOB + 2*AREA,
  localparam int unsigned PHYS = NGLOB + NWIN*2*AREA
) (
  input  logic [WB-1:0] cwp_i,
  input  arch_reg_t     reg_i,
  output logic [AW-1:0] phys_o
);
  logic          is_tmp;
  logic [WB-1:0] win;
  logic [OB-1:0] off;

  always_comb begin
    is_tmp = 32'(reg_i) >= TBASE;
    win    = cwp_i + WB'(is_tmp);
    off    = is_tmp ? OB'(32'(reg_i) - TBASE) : OB'(32'(reg_i) - NGLOB);
    if (32'(reg_i) < NGLOB) phys_o = AW'(reg_i);
    else                    phys_o = AW'(NGLOB) + AW'({win, off});
  end

  always_comb begin
    if (!$isunknown(reg_i) && !$isunknown(cwp_i) && 32'(reg_i) >= NGLOB) begin
      // R3
      phys_range_chk: assert (32'(phys_o) >= NGLOB && 32'(phys_o) < PHYS);
    end
  end
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned WB  = $clog2(NWIN),
  localparam int unsigned CW  = $clog2(NWIN+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_done_i,
  input  logic          fill_done_i,
  output logic [WB-1:0] cwp_o,
  output logic [WB-1:0] swp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [WB-1:0] cwp_q, swp_q;
  logic [CW-1:0] nsp_q;
  logic          do_ret, spill, fill;

  assign do_ret = ret_i && !call_i;
  assign ovf_o  = call_i && ((cwp_q + WB'(1)) == swp_q);
  assign unf_o  = do_ret && (cwp_q == swp_q) && (nsp_q != '0);
  assign spill  = spill_done_i && !fill_done_i;
  assign fill   = fill_done_i && !spill_done_i && (nsp_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      swp_q <= '0;
      nsp_q <= '0;
    end else begin
      if (call_i && !ovf_o)      cwp_q <= cwp_q + WB'(1);
      else if (do_ret && !unf_o) cwp_q <= cwp_q - WB'(1);
      if (spill) begin
        swp_q <= swp_q + WB'(1);
        nsp_q <= nsp_q + CW'(1);
      end else if (fill) begin
        swp_q <= swp_q - WB'(1);
        nsp_q <= nsp_q - CW'(1);
      end
    end
  end

  assign cwp_o = cwp_q;
  assign swp_o = swp_q;

  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_q));
  // R6
  call_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ovf_o) |=> cwp_q == $past(cwp_q) + WB'(1));
  // R8
  unf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_q));
  // R9
  spill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_done_i && !fill_done_i) |=> swp_q == $past(swp_q) + WB'(1));
  // R9
  fill_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done_i && !spill_done_i && nsp_q == '0) |=> $stable(swp_q));
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned PHYS = 136,
  parameter int unsigned DW   = 32,
  parameter int unsigned NRD  = 3,
  localparam int unsigned AW  = $clog2(PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          aw_en_i,
  input  logic [AW-1:0] aw_i,
  input  logic [DW-1:0] awd_i,
  input  logic          pw_en_i,
  input  logic [AW-1:0] pa_i,
  input  logic [DW-1:0] pwd_i,
  input  logic [AW-1:0] ra_i [NRD],
  output logic [DW-1:0] rd_o [NRD]
);
  logic [DW-1:0] mem_q [PHYS];
  logic          pa_ok;

  assign pa_ok = {1'b0, pa_i} < (AW+1)'(PHYS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
    end else begin
      if (aw_en_i) mem_q[aw_i] <= awd_i;
      if (pw_en_i && pa_ok) mem_q[pa_i] <= pwd_i;  // physical port wins
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_o[g] = ({1'b0, ra_i[g]} < (AW+1)'(PHYS)) ? mem_q[ra_i[g]] : '0;
  end

  // R5
  arch_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_en_i && !(pw_en_i && pa_i == aw_i)) |=> mem_q[$past(aw_i)] == $past(awd_i));
  // R10
  phys_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_en_i && pa_ok) |=> mem_q[$past(pa_i)] == $past(pwd_i));
endmodule

// File: rtl/rwin_file.sv
module rwin_file import rwin_pkg::*; #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned AREA  = 8,
  parameter int unsigned NGLOB = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned PHYS = NGLOB + NWIN*2*AREA,
  localparam int unsigned AW   = $clog2(PHYS),
  localparam int unsigned WB   = $clog2(NWIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  arch_reg_t     rs1_i,
  input  arch_reg_t     rs2_i,
  output logic [DW-1:0] rd1_o,
  output logic [DW-1:0] rd2_o,
  input  logic          we_i,
  input  arch_reg_t     wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          ovf_trap_o,
  output logic          unf_trap_o,
  input  logic          spill_done_i,
  input  logic          fill_done_i,
  input  logic          phys_we_i,
  input  logic [AW-1:0] phys_addr_i,
  input  logic [DW-1:0] phys_wd_i,
  output logic [DW-1:0] phys_rd_o,
  output logic [WB-1:0] cwp_o,
  output logic [WB-1:0] swp_o
);
  logic [WB-1:0] cwp;
  arch_reg_t     ra [3];
  logic [AW-1:0] pa [3];
  logic [AW-1:0] rdaddr [3];
  logic [DW-1:0] rdata [3];

  assign ra[0] = rs1_i;
  assign ra[1] = rs2_i;
  assign ra[2] = wa_i;

  rwin_ptr #(.NWIN(NWIN)) u_ptr (
    .clk_i, .rst_ni, .call_i, .ret_i, .spill_done_i, .fill_done_i,
    .cwp_o(cwp), .swp_o, .ovf_o(ovf_trap_o), .unf_o(unf_trap_o)
  );

  for (genvar g = 0; g < 3; g++) begin : g_map
    rwin_map #(.NWIN(NWIN), .AREA(AREA), .NGLOB(NGLOB), .AW(AW)) u_map (
      .cwp_i(cwp), .reg_i(ra[g]), .phys_o(pa[g])
    );
  end

  assign rdaddr[0] = pa[0];
  assign rdaddr[1] = pa[1];
  assign rdaddr[2] = phys_addr_i;

  rwin_store #(.PHYS(PHYS), .DW(DW), .NRD(3)) u_store (
    .clk_i, .rst_ni,
    .aw_en_i(we_i), .aw_i(pa[2]), .awd_i(wd_i),
    .pw_en_i(phys_we_i), .pa_i(phys_addr_i), .pwd_i(phys_wd_i),
    .ra_i(rdaddr), .rd_o(rdata)
  );

  assign rd1_o     = rdata[0];
  assign rd2_o     = rdata[1];
  assign phys_rd_o = rdata[2];
  assign cwp_o     = cwp;
endmodule

// File: tb/tb_rwin_file.sv
module tb_rwin_file;
  localparam int PHYS = 136;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rs1_i = '0, rs2_i = '0, wa_i = '0;
  logic [31:0] rd1_o, rd2_o, wd_i = '0, phys_wd_i = '0, phys_rd_o;
  logic        we_i = 0, call_i = 0, ret_i = 0, spill_done_i = 0, fill_done_i = 0, phys_we_i = 0;
  logic        ovf_trap_o, unf_trap_o;
  logic [7:0]  phys_addr_i = '0;
  logic [2:0]  cwp_o, swp_o;

  int tests = 0, fails = 0;
  int cur_w = 0;
  logic [31:0] exp_mem [PHYS];

  always #4 clk = ~clk;

  rwin_file dut (.clk_i(clk), .rst_ni, .rs1_i, .rs2_i, .rd1_o, .rd2_o, .we_i, .wa_i, .wd_i,
    .call_i, .ret_i, .ovf_trap_o, .unf_trap_o, .spill_done_i, .fill_done_i,
    .phys_we_i, .phys_addr_i, .phys_wd_i, .phys_rd_o, .cwp_o, .swp_o);

  function automatic int pmap(int r, int w);
    if (r < 8) return r;
    if (r >= 24) return 8 + ((w + 1) % 8) * 16 + (r - 24);
    return 8 + w * 16 + (r - 8);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic sweep(int w);
    for (int r = 0; r < 32; r++) begin
      rs1_i = 5'(r); rs2_i = 5'(31 - r); #1;
      chk(r < 8 ? "R2 rd1" : "R3 rd1", rd1_o, exp_mem[pmap(r, w)]);
      chk((31 - r) < 8 ? "R2 rd2" : "R3 rd2", rd2_o, exp_mem[pmap(31 - r, w)]);
    end
  endtask

  task automatic awr(int r, logic [31:0] v);
    we_i = 1; wa_i = 5'(r); wd_i = v;
    tick;
    we_i = 0;
    exp_mem[pmap(r, cur_w)] = v;
  endtask

  task automatic do_call(logic exp_ovf);
    call_i = 1; #1;
    chk("R7 ovf", 32'(ovf_trap_o), 32'(exp_ovf));
    tick;
    call_i = 0;
    if (!exp_ovf) cur_w = (cur_w + 1) % 8;
    chk(exp_ovf ? "R7 cwp" : "R6 call cwp", 32'(cwp_o), 32'(cur_w));
  endtask

  task automatic do_ret(logic exp_unf);
    ret_i = 1; #1;
    chk("R8 unf", 32'(unf_trap_o), 32'(exp_unf));
    tick;
    ret_i = 0;
    if (!exp_unf) cur_w = (cur_w + 7) % 8;
    chk(exp_unf ? "R8 cwp" : "R6 ret cwp", 32'(cwp_o), 32'(cur_w));
  endtask

  task automatic pulse(logic s, logic f);
    spill_done_i = s; fill_done_i = f;
    tick;
    spill_done_i = 0; fill_done_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
    #1;
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 swp", 32'(swp_o), 0);
    chk("R1 ovf", 32'(ovf_trap_o), 0);
    chk("R1 unf", 32'(unf_trap_o), 0);
    for (int i = 0; i < PHYS; i++) begin
      phys_addr_i = 8'(i); #1;
      chk("R1 phys", phys_rd_o, 0);
    end

    // fill every physical register with a unique value
    for (int i = 0; i < PHYS; i++) begin
      phys_we_i = 1; phys_addr_i = 8'(i); phys_wd_i = 32'hA500_0000 | 32'(i);
      tick;
      exp_mem[i] = 32'hA500_0000 | 32'(i);
    end
    phys_we_i = 0;
    for (int i = 0; i < PHYS; i++) begin
      phys_addr_i = 8'(i); #1;
      chk("R10 phys rd", phys_rd_o, exp_mem[i]);
    end

    for (int w = 0; w < 8; w++) begin
      sweep(w);
      for (int k = 0; k < 8; k++) awr(24 + k, 32'hC000_0000 | 32'(w << 8) | 32'(k));
      if (w == 7) begin
        do_call(1'b1);
        pulse(1'b1, 1'b0);
        chk("R9 spill swp", 32'(swp_o), 1);
        do_call(1'b0);
      end else begin
        do_call(1'b0);
      end
      for (int k = 0; k < 8; k++) begin
        rs1_i = 5'(8 + k); #1;
        chk("R4 overlap", rd1_o, 32'hC000_0000 | 32'(w << 8) | 32'(k));
      end
    end

    // cwp=0 swp=1 one spilled: return down to window 1
    for (int i = 0; i < 7; i++) do_ret(1'b0);
    chk("R8 at swp", 32'(cwp_o), 1);
    do_ret(1'b1);
    pulse(1'b0, 1'b1);
    chk("R9 fill swp", 32'(swp_o), 0);
    do_ret(1'b0);
    do_ret(1'b0);  // count 0: wraps, no trap
    pulse(1'b0, 1'b1);
    chk("R9 fill idle", 32'(swp_o), 0);
    pulse(1'b1, 1'b1);
    chk("R9 both idle", 32'(swp_o), 0);
    do_ret(1'b0);
    chk("R6 cwp6", 32'(cwp_o), 6);
    call_i = 1; ret_i = 1; #1;
    chk("R6 both ovf", 32'(ovf_trap_o), 0);
    chk("R6 both unf", 32'(unf_trap_o), 0);
    tick;
    call_i = 0; ret_i = 0;
    cur_w = 7;
    chk("R6 call wins", 32'(cwp_o), 7);

    // R5 write timing
    rs1_i = 5'd16; rs2_i = 5'd16;
    we_i = 1; wa_i = 5'd16; wd_i = 32'h1234_5678; #1;
    chk("R5 old before edge", rd1_o, exp_mem[pmap(16, 7)]);
    tick;
    we_i = 0;
    exp_mem[pmap(16, 7)] = 32'h1234_5678;
    chk("R5 new rd1", rd1_o, 32'h1234_5678);
    chk("R5 new rd2", rd2_o, 32'h1234_5678);
    phys_addr_i = 8'(pmap(16, 7)); #1;
    chk("R10 phys sees arch", phys_rd_o, 32'h1234_5678);

    // R10 priority on same physical index
    we_i = 1; wa_i = 5'd3; wd_i = 32'h1111_1111;
    phys_we_i = 1; phys_addr_i = 8'd3; phys_wd_i = 32'h2222_2222;
    tick;
    we_i = 0; phys_we_i = 0;
    exp_mem[3] = 32'h2222_2222;
    rs1_i = 5'd3; #1;
    chk("R10 priority", rd1_o, 32'h2222_2222);

    sweep(7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule